// File: doc/BRIEF.md
# Multi-Integration Conversion Averaging Filter

This block is the digital back end of a charge-integrating converter. It receives a stream of raw two's complement samples and produces one averaged word per conversion cycle. A conversion is made of L integrations. An external strobe opens each integration. Within an integration, M final samples are summed into one data point. The L data points are then summed and scaled down to a single rounded average. Both L and M are powers of two, so the scaling is an arithmetic right shift.

A configuration write sets log2(L), log2(M) and a correlated double sampling (CDS) enable. A combination whose L times M exceeds 256 points is refused and flagged. With CDS enabled, each integration first collects M reference samples and then M final samples. The data point is the final sum minus the reference sum. Reference samples do not count against the 256-point budget. An accepted configuration is held pending and is taken up only when the next conversion starts. A strobe that arrives before the open integration is complete sets a sticky overrun flag and restarts that integration.

Top module: `conv_avg_filter`

## Requirements
- R1: L = 2^cfg_log_l and M = 2^cfg_log_m. Each log code runs from 0 to 8, so L and M each take the values 1, 2, 4, ..., 256.
- R2: Exactly one result is produced per conversion of L completed integrations. res_valid is a one-cycle pulse, registered on the clock edge that accepts the last final sample of the last integration.
- R3: An integration opens only on an int_start pulse. A sample is ignored if no integration is open, if it arrives after the open integration has completed, or if it arrives in the same cycle as int_start.
- R4: A write with cfg_log_l + cfg_log_m > 8 is refused. cfg_reject pulses high in the cycle after cfg_wr, and the stored setting is unchanged. Both extremes (8,0) and (0,8) are accepted.
- R5: With cfg_cds = 1, the first M samples of an integration are reference samples and the next M are final samples. The data point is the sum of the final samples minus the sum of the reference samples. The reference samples do not enter the budget, so (0,8) is accepted with CDS on.
- R6: Let s = log_l + log_m and S = the total of all data points. The result is floor((S + 2^(s-1)) / 2^s) when s > 0, and S when s = 0. This rounds to nearest, with halves rounded toward +infinity. res_data is 21-bit two's complement; smp_data is 20-bit two's complement.
- R7: Idle cycles, either between strobes or between samples, do not change the accumulated value.
- R8: An int_start while the open integration is still incomplete sets overrun. overrun stays high until reset. The partial data point is discarded, and the same integration restarts from its first sample.
- R9: An accepted configuration takes effect only at the int_start that opens the first integration of a conversion. A write made mid-conversion leaves the current conversion on its old L, M and CDS setting.
- R10: After reset, res_valid, overrun and cfg_reject are 0, and the configuration is L = 1, M = 1 with CDS off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_log_l | input | 4 | log2 of integrations per conversion |
| cfg_log_m | input | 4 | log2 of samples per data point |
| cfg_cds | input | 1 | Correlated double sampling enable |
| cfg_reject | output | 1 | Pulse: the last write was refused |
| int_start | input | 1 | Opens one integration |
| smp_valid | input | 1 | Raw sample present |
| smp_data | input | 20 | Raw sample, two's complement |
| res_valid | output | 1 | Result pulse, once per conversion |
| res_data | output | 21 | Rounded average, two's complement |
| overrun | output | 1 | Sticky early-strobe flag |

## Verification
The bench builds the block with its default parameters: 20-bit samples and a 256-point budget. This puts both budget extremes within reach, each at full width: 256 integrations of one sample, and one integration of 256 samples, the latter also with CDS at full positive and negative input. Table vectors plant a single offset sample in each conversion. This drives the rounding onto exact halves from both signs and onto values just off a half. Directed tests cover refused writes, a configuration change in mid-conversion, early strobes, stray samples and long idle gaps.

// File: rtl/cavg_pkg.sv
// Package: shared configuration type for the conversion averaging filter.
// Assumes log codes never exceed 15, which CAVG_LOG_W bits can hold.
package cavg_pkg;
    localparam int CAVG_LOG_W = 4;

    typedef struct packed {
        logic [CAVG_LOG_W-1:0] log_l;
        logic [CAVG_LOG_W-1:0] log_m;
        logic                  cds;
    } cavg_cfg_t;
endpackage

// File: rtl/cavg_cfg_ctrl.sv
// Configuration staging: checks each write against the point budget and
// holds the last accepted setting as pending. Consumers latch the pending
// setting at the start of a conversion.
// Assumes LOG_MAX = log2 of the point budget.
module cavg_cfg_ctrl
    import cavg_pkg::*;
#(
    parameter int LOG_MAX = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  cavg_cfg_t wr_cfg,
    output cavg_cfg_t pend,
    output logic      reject
);
    localparam int SUM_W = CAVG_LOG_W + 1;

    logic [SUM_W-1:0] req_sum;
    logic             fits;

    // Budget test on the requested log codes.
    always_comb begin
        req_sum = {1'b0, wr_cfg.log_l} + {1'b0, wr_cfg.log_m};
        fits    = (req_sum <= SUM_W'(LOG_MAX));
    end

    // Store accepted writes; pulse reject for refused ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= '0;
            reject <= 1'b0;
        end else begin
            reject <= wr && !fits;
            if (wr && fits) begin
                pend <= wr_cfg;
            end
        end
    end

    AST_PEND_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, pend.log_l} + {1'b0, pend.log_m}) <= SUM_W'(LOG_MAX)); // R4
    AST_REJECT_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $stable(pend)); // R4
endmodule

// File: rtl/cavg_point_acc.sv
// Per-integration accumulator. On a start pulse it opens an integration
// and collects M final samples, preceded by M reference samples when CDS
// is on. It emits one data point, the final sum minus the reference sum,
// combinationally with the last sample.
// Assumes load_cfg is asserted only together with start.
module cavg_point_acc
    import cavg_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int LOG_MAX  = 8,
    parameter int ACC_W    = 29
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    load_cfg,
    input  logic [CAVG_LOG_W-1:0]   cfg_log_m,
    input  logic                    cfg_cds,
    input  logic                    smp_valid,
    input  logic [SAMPLE_W-1:0]     smp_data,
    output logic                    busy,
    output logic                    done,
    output logic signed [ACC_W-1:0] point
);
    localparam int CNT_W = LOG_MAX + 1;

    logic                    active;
    logic                    in_ref;
    logic [CNT_W-1:0]        cnt;
    logic signed [ACC_W-1:0] sum_ref;
    logic signed [ACC_W-1:0] sum_fin;
    logic [CAVG_LOG_W-1:0]   log_m_q;
    logic                    cds_q;
    logic [CNT_W-1:0]        m_last;
    logic                    take;
    logic                    phase_end;
    logic signed [ACC_W-1:0] smp_ext;
    logic                    eff_cds;

    // Decode sample acceptance and the phase boundary.
    always_comb begin
        m_last    = CNT_W'((32'd1 << log_m_q) - 32'd1);
        take      = active && smp_valid && !start;
        phase_end = (cnt == m_last);
        smp_ext   = ACC_W'($signed(smp_data));
        done      = take && !in_ref && phase_end;
        point     = sum_fin + smp_ext - sum_ref;
        busy      = active;
        eff_cds   = load_cfg ? cfg_cds : cds_q;
    end

    // Sequence the reference and final phases and keep their sums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            in_ref  <= 1'b0;
            cnt     <= '0;
            sum_ref <= '0;
            sum_fin <= '0;
            log_m_q <= '0;
            cds_q   <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            in_ref  <= eff_cds;
            cnt     <= '0;
            sum_ref <= '0;
            sum_fin <= '0;
            if (load_cfg) begin
                log_m_q <= cfg_log_m;
                cds_q   <= cfg_cds;
            end
        end else if (take) begin
            if (in_ref) begin
                sum_ref <= sum_ref + smp_ext;
            end else begin
                sum_fin <= sum_fin + smp_ext;
            end
            if (phase_end) begin
                cnt <= '0;
                if (in_ref) begin
                    in_ref <= 1'b0;
                end else begin
                    active <= 1'b0;
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_CNT_WITHIN_M: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt <= m_last)); // R1
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !active); // R3
    AST_REF_ONLY_CDS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ref |-> cds_q); // R5
endmodule

// File: rtl/cavg_conv_acc.sv
// Per-conversion accumulator. It sums L data points, then rounds the total
// and shifts it right by log2(L)+log2(M) into one registered result.
// Assumes point_done and conv_start never coincide.
module cavg_conv_acc
    import cavg_pkg::*;
#(
    parameter int LOG_MAX = 8,
    parameter int ACC_W   = 29,
    parameter int OUT_W   = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_start,
    input  logic [CAVG_LOG_W-1:0]   cfg_log_l,
    input  logic [CAVG_LOG_W-1:0]   cfg_log_m,
    input  logic                    point_done,
    input  logic signed [ACC_W-1:0] point_val,
    output logic                    idx_zero,
    output logic                    res_valid,
    output logic [OUT_W-1:0]        res_data
);
    localparam int IDX_W = LOG_MAX + 1;
    localparam int SH_W  = CAVG_LOG_W + 1;

    logic [IDX_W-1:0]        idx;
    logic [CAVG_LOG_W-1:0]   log_l_q;
    logic [SH_W-1:0]         shift_q;
    logic signed [ACC_W-1:0] acc;
    logic [IDX_W-1:0]        l_last;
    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] biased;
    logic signed [ACC_W-1:0] scaled;

    // Running total, rounding bias and scaled average.
    always_comb begin
        l_last   = IDX_W'((32'd1 << log_l_q) - 32'd1);
        idx_zero = (idx == '0);
        total    = acc + point_val;
        rnd      = (shift_q == '0) ? '0 : (ACC_W'(1) << (shift_q - 1'b1));
        biased   = total + rnd;
        scaled   = biased >>> shift_q;
    end

    // Count integrations, accumulate points and emit one result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            log_l_q   <= '0;
            shift_q   <= '0;
            acc       <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            if (conv_start) begin
                idx     <= '0;
                acc     <= '0;
                log_l_q <= cfg_log_l;
                shift_q <= {1'b0, cfg_log_l} + {1'b0, cfg_log_m};
            end else if (point_done) begin
                if (idx == l_last) begin
                    res_valid <= 1'b1;
                    res_data  <= scaled[OUT_W-1:0];
                    idx       <= '0;
                    acc       <= '0;
                end else begin
                    idx <= idx + 1'b1;
                    acc <= total;
                end
            end
        end
    end

    AST_IDX_WITHIN_L: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= l_last); // R1
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R2
    AST_RESULT_FROM_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(point_done)); // R2
    AST_SHIFT_IN_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q <= SH_W'(LOG_MAX)); // R4
endmodule

// File: rtl/conv_avg_filter.sv
// Top of the conversion averaging filter. It wires configuration staging,
// the per-integration point accumulator and the per-conversion averager,
// and it keeps the sticky overrun flag.
// Assumes MAX_POINTS is a power of two no larger than 2^15.
module conv_avg_filter
    import cavg_pkg::*;
#(
    parameter int SAMPLE_W   = 20,
    parameter int MAX_POINTS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [3:0]            cfg_log_l,
    input  logic [3:0]            cfg_log_m,
    input  logic                  cfg_cds,
    output logic                  cfg_reject,
    input  logic                  int_start,
    input  logic                  smp_valid,
    input  logic [SAMPLE_W-1:0]   smp_data,
    output logic                  res_valid,
    output logic [SAMPLE_W:0]     res_data,
    output logic                  overrun
);
    localparam int LOG_MAX = $clog2(MAX_POINTS);
    localparam int ACC_W   = SAMPLE_W + LOG_MAX + 1;
    localparam int OUT_W   = SAMPLE_W + 1;

    cavg_cfg_t               wr_cfg;
    cavg_cfg_t               pend;
    logic                    conv_start;
    logic                    idx_zero;
    logic                    pt_busy;
    logic                    pt_done;
    logic signed [ACC_W-1:0] pt_val;

    // Pack the write fields and detect a conversion-opening strobe.
    always_comb begin
        wr_cfg     = '{log_l: cfg_log_l, log_m: cfg_log_m, cds: cfg_cds};
        conv_start = int_start && idx_zero;
    end

    cavg_cfg_ctrl #(.LOG_MAX(LOG_MAX)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .pend   (pend),
        .reject (cfg_reject)
    );

    cavg_point_acc #(
        .SAMPLE_W (SAMPLE_W),
        .LOG_MAX  (LOG_MAX),
        .ACC_W    (ACC_W)
    ) u_point (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (int_start),
        .load_cfg  (conv_start),
        .cfg_log_m (pend.log_m),
        .cfg_cds   (pend.cds),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .busy      (pt_busy),
        .done      (pt_done),
        .point     (pt_val)
    );

    cavg_conv_acc #(
        .LOG_MAX (LOG_MAX),
        .ACC_W   (ACC_W),
        .OUT_W   (OUT_W)
    ) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .cfg_log_l  (pend.log_l),
        .cfg_log_m  (pend.log_m),
        .point_done (pt_done),
        .point_val  (pt_val),
        .idx_zero   (idx_zero),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    // Sticky flag for a strobe that cuts an integration short.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (int_start && pt_busy) begin
            overrun <= 1'b1;
        end
    end

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R8
    AST_NO_SAMPLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid || int_start) |=> !res_valid); // R3
    AST_REJECT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reject |-> $past(cfg_wr)); // R4
endmodule

// File: tb/conv_avg_filter_tb.sv
module conv_avg_filter_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int ll; int lm; int cds; int refv; int fin; int bump; int expv;
    } vec_t;

    // Each conversion: final samples equal fin, with bump added to the first.
    localparam vec_t VECS [0:9] = '{
        '{0, 0, 0, 0, 1234, 0, 1234},
        '{2, 1, 0, 0, -500, 3, -500},
        '{2, 1, 0, 0, -500, 4, -499},
        '{1, 1, 0, 0, 100, -2, 100},
        '{1, 1, 0, 0, 100, -3, 99},
        '{0, 8, 0, 0, 524287, 0, 524287},
        '{8, 0, 0, 0, -524288, 0, -524288},
        '{1, 2, 1, 1000, 250, 0, -750},
        '{0, 8, 1, -524288, 524287, 0, 1048575},
        '{3, 2, 0, 0, 7, 17, 8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_log_l = '0;
    logic [3:0]  cfg_log_m = '0;
    logic        cfg_cds = 1'b0;
    logic        cfg_reject;
    logic        int_start = 1'b0;
    logic        smp_valid = 1'b0;
    logic [19:0] smp_data = '0;
    logic        res_valid;
    logic [20:0] res_data;
    logic        overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_avg_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_log_l(cfg_log_l),
        .cfg_log_m(cfg_log_m), .cfg_cds(cfg_cds), .cfg_reject(cfg_reject),
        .int_start(int_start), .smp_valid(smp_valid), .smp_data(smp_data),
        .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One cycle of strobe/sample stimulus, sampled 1 time unit after the edge.
    task automatic drive(input logic s, input logic v, input int d);
        @(negedge clk);
        cfg_wr = 1'b0; int_start = s; smp_valid = v; smp_data = d[19:0];
        @(posedge clk); #1;
    endtask

    task automatic write_cfg(input int ll, input int lm, input int cds);
        @(negedge clk);
        int_start = 1'b0; smp_valid = 1'b0; cfg_wr = 1'b1;
        cfg_log_l = ll[3:0]; cfg_log_m = lm[3:0]; cfg_cds = cds[0];
        @(posedge clk); #1;
    endtask

    task automatic expect_result(input string req, input int expv);
        chk(res_valid === 1'b1, req, int'(res_valid), 1);
        chk($signed(res_data) == expv, req, $signed(res_data), expv);
    endtask

    task automatic run_vec(input vec_t v, input int n);
        int nl = 1 << v.ll;
        int nm = 1 << v.lm;
        int k = 0;
        write_cfg(v.ll, v.lm, v.cds);
        chk(cfg_reject === 1'b0, $sformatf("R4 vec%0d accept", n), int'(cfg_reject), 0);
        for (int i = 0; i < nl; i++) begin
            drive(1'b1, 1'b0, 0);
            if (i % 3 == 1) drive(1'b0, 1'b0, 0); // R7 gap between strobe and samples
            if (v.cds != 0) begin
                for (int j = 0; j < nm; j++) drive(1'b0, 1'b1, v.refv);
            end
            for (int j = 0; j < nm; j++) begin
                int val = v.fin + ((k == 0) ? v.bump : 0);
                k++;
                if (j == 1) drive(1'b0, 1'b0, 0); // R7 gap between samples
                drive(1'b0, 1'b1, val);
                if (i == nl - 1 && j == nm - 1) begin
                    expect_result($sformatf("R6 R2 vec%0d", n), v.expv);
                end else if (res_valid !== 1'b0) begin
                    chk(1'b0, $sformatf("R2 vec%0d early result", n), 1, 0);
                end
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(res_valid === 1'b0, "R10 res_valid in reset", int'(res_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(res_valid === 1'b0, "R10 res_valid", int'(res_valid), 0);
        chk(overrun === 1'b0, "R10 overrun", int'(overrun), 0);
        chk(cfg_reject === 1'b0, "R10 cfg_reject", int'(cfg_reject), 0);
        // R10 default L=1 M=1: one sample yields a result
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 321);
        expect_result("R10 default config", 321);

        for (int n = 0; n < 10; n++) run_vec(VECS[n], n);

        // R4 refused writes keep L=2^0, M=2^0
        write_cfg(0, 0, 0);
        write_cfg(4, 5, 0);
        chk(cfg_reject === 1'b1, "R4 reject 4+5", int'(cfg_reject), 1);
        write_cfg(9, 0, 1);
        chk(cfg_reject === 1'b1, "R4 reject 9+0", int'(cfg_reject), 1);
        drive(1'b0, 1'b0, 0);
        chk(cfg_reject === 1'b0, "R4 reject is a pulse", int'(cfg_reject), 0);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 42);
        expect_result("R4 setting unchanged", 42);

        // R3 stray samples: L=1 M=2
        write_cfg(0, 1, 0);
        drive(1'b0, 1'b1, 9999);
        chk(res_valid === 1'b0, "R3 sample before strobe", int'(res_valid), 0);
        drive(1'b1, 1'b1, 7777);
        drive(1'b0, 1'b1, 10);
        drive(1'b0, 1'b1, 20);
        expect_result("R3 strobe-cycle sample ignored", 15);
        drive(1'b0, 1'b1, 5000);
        chk(res_valid === 1'b0, "R3 sample after completion", int'(res_valid), 0);

        // R7 long idle gap: L=2 M=1
        write_cfg(1, 0, 0);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 8);
        begin
            int seen = 0;
            for (int g = 0; g < 50; g++) begin
                drive(1'b0, 1'b0, 0);
                if (res_valid !== 1'b0) seen++;
            end
            chk(seen == 0, "R7 no result during gap", seen, 0);
        end
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 9);
        expect_result("R7 R6 after gap", 9);

        // R8 overrun: L=2 M=2
        write_cfg(1, 1, 0);
        chk(overrun === 1'b0, "R8 clear before", int'(overrun), 0);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 100);
        drive(1'b1, 1'b0, 0);
        chk(overrun === 1'b1, "R8 early strobe flags", int'(overrun), 1);
        drive(1'b0, 1'b1, 10);
        drive(1'b0, 1'b1, 20);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 30);
        drive(1'b0, 1'b1, 40);
        expect_result("R8 partial discarded", 25);
        chk(overrun === 1'b1, "R8 sticky", int'(overrun), 1);

        // R9 mid-conversion write: L=2 M=1, then L=1
        write_cfg(1, 0, 0);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 10);
        write_cfg(0, 0, 0);
        chk(cfg_reject === 1'b0, "R9 write accepted", int'(cfg_reject), 0);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 30);
        expect_result("R9 old config kept", 20);
        drive(1'b1, 1'b0, 0);
        drive(1'b0, 1'b1, 55);
        expect_result("R9 new config at next conversion", 55);

        // R10 reset clears the sticky flag
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(overrun === 1'b0, "R10 overrun cleared", int'(overrun), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule